// File: doc/BRIEF.md
# Real-Time Clock Status and Alarm Flag Register Bank

This block holds the status and control bits that a real-time clock exposes to software over a small addressed register bus. It keeps a sticky flag recording that the oscillator has stopped, an enable for the 32.768 kHz clock output pin, a busy indicator for the temperature-compensation engine, and one sticky flag per alarm. The alarm flags, together with per-alarm enables and an interrupt-mode bit supplied from elsewhere, drive a shared active-low open-drain interrupt line. A second register holds an 8-bit two's-complement aging trim value that is presented on an output port for the crystal trim logic.

Software reads the bank combinationally: read data follows the address in the same cycle. Writes take effect at the clock edge where the write strobe is sampled. The sticky flags can only be cleared by software writing 0 to them; writing 1 leaves them as they are. Hardware set events take priority over a software clear in the same cycle. The busy bit is owned by hardware. A conversion request that arrives while the engine is busy is dropped, so the running compensation sequence is never restarted.

Top module: `rtc_stat_regs`

## Requirements
- R1: After reset the status register (address 0x0F) reads 0x88: the oscillator-stop flag (bit 7) and clock-output enable (bit 3) are 1, and busy (bit 2) and both alarm flags (bits 1 and 0) are 0. The trim register (address 0x10) reads 0x00.
- R2: The oscillator-stop flag is set at every clock edge where `osc_halted_i` is 1. It then stays 1 until a status write with bit 7 = 0. A status write with bit 7 = 1 leaves the flag unchanged.
- R3: Alarm flag i is held in status bit i, with alarm 1 in bit 0 and alarm 2 in bit 1. It is set at the clock edge where `alm_hit_i[i]` is 1 and stays set until a status write with bit i = 0. A status write with bit i = 1 leaves the flag unchanged.
- R4: When a hardware set event and a software clear of the same flag fall in the same cycle, the flag ends up 1.
- R5: Status bit 3 is a read/write clock-output enable. `clk32_oe_o` equals this bit. `clk32_o` follows `ref32_i` while the bit is 1 and is 0 while the bit is 0.
- R6: A `conv_req_i` sampled while not busy sets status bit 2 at that edge and raises `conv_start_o` for exactly one cycle. Busy returns to 0 at the first edge where `comp_idle_i` is 1 while busy.
- R7: A `conv_req_i` sampled while busy is ignored: `conv_start_o` stays 0 and busy stays 1.
- R8: Software writes never change the busy bit.
- R9: Status bits 6 to 4 always read 0.
- R10: `irq_n_o` is 0 exactly when `irq_mode_i` is 1 and some alarm has both its flag and its enable at 1 (enable bit 0 pairs with alarm 1). Otherwise it is 1. It follows flag changes in the same cycle, with no added register.
- R11: The register at 0x10 stores any byte written to it. It reads back that byte and presents it on `aging_trim_o`.
- R12: Reads from any address other than 0x0F and 0x10 return 0. Writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| osc_halted_i | input | 1 | Oscillator currently stopped |
| alm_hit_i | input | 2 | Alarm time-match pulses, bit 0 = alarm 1 |
| conv_req_i | input | 1 | Temperature conversion request |
| comp_idle_i | input | 1 | Compensation engine reports idle |
| alm_ie_i | input | 2 | Alarm interrupt enables, bit 0 = alarm 1 |
| irq_mode_i | input | 1 | Interrupt-mode control (1 routes alarms to the pin) |
| ref32_i | input | 1 | 32.768 kHz square-wave source |
| clk32_o | output | 1 | Gated 32.768 kHz output |
| clk32_oe_o | output | 1 | Output enable of the clock pin (0 models high impedance) |
| irq_n_o | output | 1 | Open-drain interrupt level, 0 = pulled low |
| conv_start_o | output | 1 | One-cycle pulse that starts a compensation run |
| aging_trim_o | output | 8 | Two's-complement aging offset |

## Verification
Register updates land at the clock edge that samples a write or a hardware event. Read data, the interrupt level and the clock-output pins are combinational from those registers, so every such result is due one edge after its stimulus. The conversion start pulse is registered and shows in that same cycle only. The bench drives inputs on the falling edge and lets one rising edge pass. It samples at the next falling edge, or a delta after a combinational input change, so it always looks exactly one edge after the stimulus. It then checks the pulse again one edge later to confirm that it has dropped.

// File: rtl/rtc_stat_pkg.sv
// Shared constants for the RTC status register bank.
// Assumes an 8-bit data path; bit positions are fixed because software
// decodes them.
package rtc_stat_pkg;
    localparam int DATA_W   = 8;
    localparam int N_ALM    = 2;
    localparam int OSF_BIT  = 7;
    localparam int EN32_BIT = 3;
    localparam int BUSY_BIT = 2;
    localparam int ALM_BIT0 = 0;

    // Assemble the status byte; unused bits read as zero.
    function automatic logic [DATA_W-1:0] pack_status(
        input logic             osf,
        input logic             en32,
        input logic             busy,
        input logic [N_ALM-1:0] alm
    );
        logic [DATA_W-1:0] v;
        v = '0;
        v[OSF_BIT]  = osf;
        v[EN32_BIT] = en32;
        v[BUSY_BIT] = busy;
        for (int i = 0; i < N_ALM; i++) begin
            v[ALM_BIT0+i] = alm[i];
        end
        return v;
    endfunction
endpackage

// File: rtl/rtc_sticky_flag.sv
// Sticky flag: set by a hardware event, cleared only by an explicit
// software clear. A set and a clear in the same cycle leave the flag set.
// Assumes set_i and clr_i are synchronous to clk.
module rtc_sticky_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag state with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= RST_VAL;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/rtc_conv_busy.sv
// Busy tracker for the compensation engine. An accepted request raises
// busy and emits a one-cycle start pulse. Requests seen while busy are
// dropped. Busy falls when the engine reports idle.
// Assumes the engine drops comp idle within a cycle of the start pulse.
module rtc_conv_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic idle_i,
    output logic busy_o,
    output logic start_o
);
    // Busy state and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            start_o <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (!busy_o && req_i) begin
                busy_o  <= 1'b1;
                start_o <= 1'b1;
            end else if (busy_o && idle_i) begin
                busy_o  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rtc_alarm_irq.sv
// Combines alarm flags with their enables and the interrupt-mode bit
// into an open-drain, active-low interrupt level.
// Purely combinational so the pin follows the flags in the same cycle.
module rtc_alarm_irq #(
    parameter int N_ALM = 2
) (
    input  logic [N_ALM-1:0] flag_i,
    input  logic [N_ALM-1:0] ie_i,
    input  logic             mode_i,
    output logic             irq_n_o
);
    logic [N_ALM-1:0] qual;

    // Per-alarm qualification.
    for (genvar g = 0; g < N_ALM; g++) begin : g_qual
        assign qual[g] = flag_i[g] & ie_i[g];
    end

    // Pull the line low while any qualified alarm is pending in interrupt mode.
    always_comb irq_n_o = ~(mode_i & (|qual));
endmodule

// File: rtl/rtc_stat_regs.sv
// RTC status/control bank: oscillator-stop flag, clock-output enable,
// compensation busy, alarm flags with interrupt, and aging trim register.
// Assumes a single-cycle write strobe protocol and combinational reads.
module rtc_stat_regs
    import rtc_stat_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F,
    parameter logic [ADDR_W-1:0] TRIM_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              osc_halted_i,
    input  logic [N_ALM-1:0]  alm_hit_i,
    input  logic              conv_req_i,
    input  logic              comp_idle_i,
    input  logic [N_ALM-1:0]  alm_ie_i,
    input  logic              irq_mode_i,
    input  logic              ref32_i,
    output logic              clk32_o,
    output logic              clk32_oe_o,
    output logic              irq_n_o,
    output logic              conv_start_o,
    output logic [DATA_W-1:0] aging_trim_o
);
    logic              stat_wr;
    logic              trim_wr;
    logic              osf_q;
    logic              en32_q;
    logic              busy_q;
    logic [N_ALM-1:0]  alm_flag_q;
    logic [DATA_W-1:0] trim_q;

    // Address decode of bus writes.
    always_comb begin
        stat_wr = bus_we && (bus_addr == STAT_ADDR);
        trim_wr = bus_we && (bus_addr == TRIM_ADDR);
    end

    rtc_sticky_flag #(.RST_VAL(1'b1)) u_osf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (osc_halted_i),
        .clr_i  (stat_wr && !bus_wdata[OSF_BIT]),
        .flag_o (osf_q)
    );

    for (genvar g = 0; g < N_ALM; g++) begin : g_alm
        rtc_sticky_flag #(.RST_VAL(1'b0)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (alm_hit_i[g]),
            .clr_i  (stat_wr && !bus_wdata[ALM_BIT0+g]),
            .flag_o (alm_flag_q[g])
        );
    end

    rtc_conv_busy u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (conv_req_i),
        .idle_i  (comp_idle_i),
        .busy_o  (busy_q),
        .start_o (conv_start_o)
    );

    rtc_alarm_irq #(.N_ALM(N_ALM)) u_irq (
        .flag_i  (alm_flag_q),
        .ie_i    (alm_ie_i),
        .mode_i  (irq_mode_i),
        .irq_n_o (irq_n_o)
    );

    // Clock-output enable bit, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en32_q <= 1'b1;
        else if (stat_wr) en32_q <= bus_wdata[EN32_BIT];
    end

    // Aging trim register.
    always_ff @(posedge clk) begin
        if (!rst_n)       trim_q <= '0;
        else if (trim_wr) trim_q <= bus_wdata;
    end

    // Clock pin gating and trim output.
    always_comb begin
        clk32_oe_o   = en32_q;
        clk32_o      = ref32_i & en32_q;
        aging_trim_o = trim_q;
    end

    // Read multiplexer.
    always_comb begin
        if (bus_addr == STAT_ADDR)      bus_rdata = pack_status(osf_q, en32_q, busy_q, alm_flag_q);
        else if (bus_addr == TRIM_ADDR) bus_rdata = trim_q;
        else                            bus_rdata = '0;
    end
endmodule

// File: rtl/rtc_stat_regs_chk.sv
// Assertion checker for rtc_stat_regs, attached by bind.
// Observes ports and the flag registers; drives nothing.
module rtc_stat_regs_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic              osc_halted_i,
    input logic [1:0]        alm_hit_i,
    input logic              conv_req_i,
    input logic              comp_idle_i,
    input logic              irq_mode_i,
    input logic              irq_n_o,
    input logic              conv_start_o,
    input logic              osf_q,
    input logic              busy_q,
    input logic [1:0]        alm_flag_q
);
    logic swr;
    always_comb swr = bus_we && (bus_addr == STAT_ADDR);

    // R2
    osf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_halted_i |=> osf_q);
    // R2
    osf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osf_q && !(swr && !bus_wdata[7])) |=> osf_q);
    // R3
    alm1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_hit_i[0] |=> alm_flag_q[0]);
    // R3
    alm2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag_q[1] && !(swr && !bus_wdata[1])) |=> alm_flag_q[1]);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_hit_i[1] && swr && !bus_wdata[1]) |=> alm_flag_q[1]);
    // R6
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && conv_req_i) |=> (busy_q && conv_start_o));
    // R7
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !conv_start_o);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !comp_idle_i) |=> busy_q);
    // R8
    busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !conv_req_i) |=> !busy_q);
    // R10
    irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mode_i |-> irq_n_o);
endmodule

bind rtc_stat_regs rtc_stat_regs_chk #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .osc_halted_i (osc_halted_i),
    .alm_hit_i    (alm_hit_i),
    .conv_req_i   (conv_req_i),
    .comp_idle_i  (comp_idle_i),
    .irq_mode_i   (irq_mode_i),
    .irq_n_o      (irq_n_o),
    .conv_start_o (conv_start_o),
    .osf_q        (osf_q),
    .busy_q       (busy_q),
    .alm_flag_q   (alm_flag_q)
);

// File: tb/rtc_stat_regs_test.sv
module rtc_stat_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       osc_halted_i = 1'b0;
    logic [1:0] alm_hit_i = 2'b00;
    logic       conv_req_i = 1'b0;
    logic       comp_idle_i = 1'b0;
    logic [1:0] alm_ie_i = 2'b00;
    logic       irq_mode_i = 1'b0;
    logic       ref32_i = 1'b0;
    logic       clk32_o, clk32_oe_o, irq_n_o, conv_start_o;
    logic [7:0] aging_trim_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [7:0] STAT = 8'h0F;
    localparam logic [7:0] TRIM = 8'h10;

    always #10 clk = ~clk;

    rtc_stat_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_halted_i(osc_halted_i),
        .alm_hit_i(alm_hit_i), .conv_req_i(conv_req_i), .comp_idle_i(comp_idle_i),
        .alm_ie_i(alm_ie_i), .irq_mode_i(irq_mode_i), .ref32_i(ref32_i),
        .clk32_o(clk32_o), .clk32_oe_o(clk32_oe_o), .irq_n_o(irq_n_o),
        .conv_start_o(conv_start_o), .aging_trim_o(aging_trim_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then return at the following falling edge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(STAT, r); chk("R1 status", r, 8'h88);
        rd(TRIM, r); chk("R1 trim", r, 8'h00);
        chk("R1 oe", {7'd0, clk32_oe_o}, 8'h01);
        chk("R1 irq", {7'd0, irq_n_o}, 8'h01);

        // R2 oscillator-stop flag
        wr(STAT, 8'h08); rd(STAT, r); chk("R2 clear", r, 8'h08);
        wr(STAT, 8'h88); rd(STAT, r); chk("R2 write1 no effect", r, 8'h08);
        osc_halted_i = 1'b1; cyc(); osc_halted_i = 1'b0;
        rd(STAT, r); chk("R2 set", r, 8'h88);
        cyc(); rd(STAT, r); chk("R2 sticky", r, 8'h88);
        // R4 set wins over clear
        osc_halted_i = 1'b1; wr(STAT, 8'h08); osc_halted_i = 1'b0;
        rd(STAT, r); chk("R4 osf", r, 8'h88);

        // R3 alarm flags
        wr(STAT, 8'h08);
        alm_hit_i = 2'b11; cyc(); alm_hit_i = 2'b00;
        rd(STAT, r); chk("R3 both set", r, 8'h0B);
        wr(STAT, 8'h0A); rd(STAT, r); chk("R3 clear alarm1", r, 8'h0A);
        wr(STAT, 8'h09); rd(STAT, r); chk("R3 clear alarm2", r, 8'h08);
        alm_hit_i = 2'b10; wr(STAT, 8'h08); alm_hit_i = 2'b00;
        rd(STAT, r); chk("R4 alarm2", r, 8'h0A);

        // R2 R3 R5 R8 R9 exhaustive status write sweep
        for (int w = 0; w < 256; w++) begin
            osc_halted_i = 1'b1; alm_hit_i = 2'b11; cyc();
            osc_halted_i = 1'b0; alm_hit_i = 2'b00;
            wr(STAT, w[7:0]);
            rd(STAT, r); chk("R2 R3 R5 R8 R9 sweep", r, w[7:0] & 8'h8B);
            chk("R5 oe sweep", {7'd0, clk32_oe_o}, {7'd0, w[3]});
        end

        // R5 clock gating
        wr(STAT, 8'h08); ref32_i = 1'b1; #1;
        chk("R5 clk on", {7'd0, clk32_o}, 8'h01);
        wr(STAT, 8'h00); #1;
        chk("R5 clk off", {7'd0, clk32_o}, 8'h00);
        chk("R5 oe off", {7'd0, clk32_oe_o}, 8'h00);
        ref32_i = 1'b0; wr(STAT, 8'h08);

        // R6 busy and start pulse
        conv_req_i = 1'b1; cyc(); conv_req_i = 1'b0;
        rd(STAT, r); chk("R6 busy set", r & 8'h04, 8'h04);
        chk("R6 start pulse", {7'd0, conv_start_o}, 8'h01);
        cyc(); chk("R6 start one cycle", {7'd0, conv_start_o}, 8'h00);
        // R7 request while busy
        conv_req_i = 1'b1; cyc(); conv_req_i = 1'b0;
        chk("R7 no restart", {7'd0, conv_start_o}, 8'h00);
        rd(STAT, r); chk("R7 still busy", r & 8'h04, 8'h04);
        // R8 software cannot clear busy
        wr(STAT, 8'h08); rd(STAT, r); chk("R8 write while busy", r & 8'h04, 8'h04);
        comp_idle_i = 1'b1; cyc(); comp_idle_i = 1'b0;
        rd(STAT, r); chk("R6 busy clears", r & 8'h04, 8'h00);

        // R10 interrupt sweep
        for (int f = 0; f < 4; f++) begin
            for (int ie = 0; ie < 4; ie++) begin
                for (int m = 0; m < 2; m++) begin
                    logic e;
                    alm_ie_i = 2'b00; irq_mode_i = 1'b0;
                    wr(STAT, 8'h08);
                    alm_hit_i = f[1:0]; cyc(); alm_hit_i = 2'b00;
                    alm_ie_i = ie[1:0]; irq_mode_i = m[0]; #1;
                    e = !(m[0] && ((f[1:0] & ie[1:0]) != 2'b00));
                    chk("R10 irq level", {7'd0, irq_n_o}, {7'd0, e});
                    wr(STAT, 8'h08);
                    chk("R10 release", {7'd0, irq_n_o}, 8'h01);
                end
            end
        end
        alm_ie_i = 2'b00; irq_mode_i = 1'b0;

        // R11 trim sweep
        for (int v = 0; v < 256; v++) begin
            wr(TRIM, v[7:0]);
            rd(TRIM, r); chk("R11 readback", r, v[7:0]);
            chk("R11 port", aging_trim_o, v[7:0]);
        end

        // R12 other addresses
        wr(TRIM, 8'hC3);
        wr(8'h11, 8'h55); rd(8'h11, r); chk("R12 read zero", r, 8'h00);
        chk("R12 trim untouched", aging_trim_o, 8'hC3);
        wr(8'h0E, 8'h00); rd(STAT, r); chk("R12 status untouched", r, 8'h08);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule